// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle register bus. Software programs a 16-bit timeout value, picks which of three count-enable strobes drives the timer, chooses a prescale ratio between 1 and 1024 in powers of four, and then enables counting. A 16-bit up-counter advances once per prescaled tick. When the count reaches the timeout value, the block raises a one-cycle reset request toward the system reset logic. Software keeps the system alive by rewriting the counter, normally with zero, before the timeout is reached.

The three count sources arrive as enable strobes that are already synchronous to the block clock: the peripheral clock, a real-time clock and an external clock. The control word selects them with one bit each. All four registers read back without side effects, and the counter register returns the live count. Reconfiguration follows a fixed order: disable, clear the source bits, load the timeout, zero the counter, set the source, re-enable. That order never produces a reset request on its own.

Top module: `wdog_top`

## Requirements
- R1: After synchronous reset, the timeout value, enable bit, counter and control word all read as zero, and `rst_req` is low.
- R2: Register word index 0 (byte 0x0) holds the 16-bit timeout value, index 1 (0x4) holds the enable in bit 0, index 2 (0x8) holds the 16-bit counter, and index 3 (0xC) holds the control word: bits [2:0] are source selects and bits [5:3] are the prescale code. Unused bits are discarded on write and read back as zero. A read shows the value currently held.
- R3: Control bit 0 enables `src_stb[0]` (peripheral clock), bit 1 enables `src_stb[1]` (real-time clock) and bit 2 enables `src_stb[2]` (external clock). A strobe on a source whose bit is clear has no effect on the count.
- R4: Prescale code n (0 to 5) makes the counter step once for every 4^n strobes of the selected source. Codes 6 and 7 behave as code 5, that is one step per 1024 strobes.
- R5: The counter holds its value while the enable bit is 0 or no source bit is set. Prescaler progress is discarded while counting is stopped and on every write to the control or counter register.
- R6: A write to the counter register loads the written value at the next clock edge and takes priority over counting. Writing 0 restarts the timeout.
- R7: When counting is running and the counter equals the timeout value, `rst_req` is high for exactly one cycle: the cycle after the edge at which the match appeared. The counter then holds at the timeout value. No further pulse occurs until the match condition goes away and comes back.
- R8: The reconfiguration order (disable, control with no source, timeout, counter = 0, control with source, enable) produces no `rst_req` while it is carried out, even while strobes are active.
- R9: When the counter is above the timeout value, counting wraps from 0xFFFF to 0x0000 and continues up to the timeout value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid in this cycle |
| bus_wr | input | 1 | Access is a write when high |
| bus_addr | input | 2 | Register word index (byte address bits [3:2]) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| src_stb | input | 3 | Synchronous count-enable strobes: [0] peripheral, [1] real-time, [2] external |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A wrong internal state shows at the ports mainly through the counter read path and the reset request. A lost or extra prescaler tick moves the readable count by one within one prescale period. An error in the match edge logic shows as a missing, doubled or stretched `rst_req` in the cycle after the count equals the timeout. The bench keeps the counter address on the bus whenever it is idle and compares the read data and `rst_req` every cycle against a model built from the requirements. Any divergence is therefore reported in the cycle it first appears, not only at the timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W     = 16;
    localparam int NSRC       = 3;
    localparam int PRE_CODE_W = 3;
    localparam int MAX_CODE   = 5;
    localparam int PRE_W      = 2 * MAX_CODE;
    localparam int CTRL_W     = NSRC + PRE_CODE_W;
    localparam int WIDX_W     = 2;

    typedef enum logic [WIDX_W-1:0] {
        RSEL_LIMIT = 2'd0,
        RSEL_RUN   = 2'd1,
        RSEL_COUNT = 2'd2,
        RSEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRE_CODE_W-1:0] pre_code;
        logic [NSRC-1:0]       src;
    } ctrl_t;

    typedef struct packed {
        logic                  valid;
        reg_sel_e              target;
        logic [DATA_W-1:0]     data;
    } wr_req_t;

    // Terminal value of the prescale counter: 4^code - 1, saturating at MAX_CODE.
    function automatic logic [PRE_W-1:0] pre_limit(input logic [PRE_CODE_W-1:0] code);
        logic [PRE_W-1:0] lim;
        lim = '0;
        for (int i = 0; i < MAX_CODE; i++) begin
            if (int'(code) > i) begin
                lim = {lim[PRE_W-3:0], 2'b11};
            end
        end
        return lim;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [WIDX_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W-1:0]     cnt_val,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [DATA_W-1:0]     limit_q,
    output logic                  en_q,
    output ctrl_t                 ctrl_q,
    output logic                  cnt_we,
    output logic                  ctrl_we,
    output logic [DATA_W-1:0]     cnt_wdata
);

    wr_req_t  wreq;
    reg_sel_e rsel;

    assign rsel = reg_sel_e'(bus_addr);

    always_comb begin
        wreq.valid  = bus_sel && bus_wr;
        wreq.target = rsel;
        wreq.data   = bus_wdata;
    end

    assign cnt_we    = wreq.valid && (wreq.target == RSEL_COUNT);
    assign ctrl_we   = wreq.valid && (wreq.target == RSEL_CTRL);
    assign cnt_wdata = wreq.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            en_q    <= 1'b0;
            ctrl_q  <= '0;
        end else if (wreq.valid) begin
            unique case (wreq.target)
                RSEL_LIMIT: limit_q <= wreq.data;
                RSEL_RUN:   en_q    <= wreq.data[0];
                RSEL_CTRL:  ctrl_q  <= ctrl_t'(wreq.data[CTRL_W-1:0]);
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            RSEL_LIMIT: bus_rdata = limit_q;
            RSEL_RUN:   bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
            RSEL_COUNT: bus_rdata = cnt_val;
            RSEL_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       src_stb,
    input  ctrl_t                 ctrl,
    input  logic                  clr,
    output logic                  tick
);

    logic [NSRC-1:0]  gated;
    logic             strobe;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             at_lim;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign gated[g] = src_stb[g] & ctrl.src[g];
    end

    assign strobe = |gated;
    assign lim    = pre_limit(ctrl.pre_code);
    assign at_lim = (pre_q == lim);
    assign tick   = strobe && at_lim && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (strobe) begin
            pre_q <= at_lim ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  tick,
    input  logic [DATA_W-1:0]     limit,
    input  logic                  cnt_we,
    input  logic [DATA_W-1:0]     cnt_wdata,
    output logic [DATA_W-1:0]     cnt_q,
    output logic                  rst_req
);

    logic match;
    logic match_q;

    assign match = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            match_q <= match;
            rst_req <= match && !match_q;
            if (cnt_we) begin
                cnt_q <= cnt_wdata;
            end else if (tick && run && !match) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [3:2]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NSRC-1:0]       src_stb,
    output logic                  rst_req
);

    logic [DATA_W-1:0] limit_q;
    logic              en_q;
    ctrl_t             ctrl_q;
    logic              cnt_we;
    logic              ctrl_we;
    logic [DATA_W-1:0] cnt_wdata;
    logic [DATA_W-1:0] cnt_q;
    logic              run;
    logic              pre_clr;
    logic              pre_tick;

    assign run     = en_q && (|ctrl_q.src);
    assign pre_clr = !run || cnt_we || ctrl_we;

    wdog_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_q),
        .bus_rdata (bus_rdata),
        .limit_q   (limit_q),
        .en_q      (en_q),
        .ctrl_q    (ctrl_q),
        .cnt_we    (cnt_we),
        .ctrl_we   (ctrl_we),
        .cnt_wdata (cnt_wdata)
    );

    wdog_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .src_stb (src_stb),
        .ctrl    (ctrl_q),
        .clr     (pre_clr),
        .tick    (pre_tick)
    );

    wdog_count u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (pre_tick),
        .limit     (limit_q),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .cnt_q     (cnt_q),
        .rst_req   (rst_req)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] cnt_wdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] limit,
    input  logic              rst_req
);

    // R7: the request never lasts more than one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7: a request is always caused by a running match one cycle earlier
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(run && (cnt == limit)));

    // R7: counter holds once the match is reached
    a_r7_hold_match: assert property (@(posedge clk) disable iff (rst)
        (run && (cnt == limit) && !cnt_we) |=> $stable(cnt));

    // R5: stopped counting keeps the count
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(cnt));

    // R3: without a prescaled tick the count does not move
    a_r3_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(cnt));

    // R6: a counter write is loaded at the next edge
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt == $past(cnt_wdata)));

    // R9: any change not caused by a write is a single step, wrapping at the top
    a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
        (!cnt_we && tick && run && (cnt != limit)) |=> (cnt == DATA_W'($past(cnt) + 1'b1)));

endmodule

bind wdog_top wdog_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tick      (pre_tick),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt       (cnt_q),
    .limit     (limit_q),
    .rst_req   (rst_req)
);

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  addr = 4'h8;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  src_stb = '0;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    wdog_top uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (addr[3:2]),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_stb   (src_stb),
        .rst_req   (rst_req)
    );

    // Reference model written from the requirements
    logic [15:0] m_lim, m_cnt;
    logic        m_en, m_mq, m_req;
    logic [5:0]  m_ctrl;
    logic [9:0]  m_pre;

    function automatic logic [9:0] lim_of(input logic [2:0] code);
        if (code >= 3'd5) return 10'd1023;
        return 10'((1 << (2 * code)) - 1);
    endfunction

    always @(posedge clk) begin
        logic run, stb, wr, tk, mt;
        logic [9:0] pl;
        if (rst) begin
            m_lim <= '0; m_cnt <= '0; m_en <= 1'b0; m_ctrl <= '0;
            m_pre <= '0; m_mq <= 1'b0; m_req <= 1'b0;
        end else begin
            run = m_en && (|m_ctrl[2:0]);
            stb = |(m_ctrl[2:0] & src_stb);
            wr  = bus_sel && bus_wr;
            pl  = lim_of(m_ctrl[5:3]);
            mt  = run && (m_cnt == m_lim);
            tk  = run && stb && (m_pre == pl) && !(wr && addr[3:2] == 2'd3) && !(wr && addr[3:2] == 2'd2);
            m_mq  <= mt;
            m_req <= mt && !m_mq;
            if (wr && addr[3:2] == 2'd2) m_cnt <= bus_wdata;
            else if (tk && !mt) m_cnt <= m_cnt + 16'd1;
            if (!run || (wr && addr[3:2] >= 2'd2)) m_pre <= '0;
            else if (stb) m_pre <= (m_pre == pl) ? 10'd0 : m_pre + 10'd1;
            if (wr && addr[3:2] == 2'd0) m_lim <= bus_wdata;
            if (wr && addr[3:2] == 2'd1) m_en <= bus_wdata[0];
            if (wr && addr[3:2] == 2'd3) m_ctrl <= bus_wdata[5:0];
        end
    end

    function automatic logic [15:0] exp_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_lim;
            2'd1: return {15'd0, m_en};
            2'd2: return m_cnt;
            default: return {10'd0, m_ctrl};
        endcase
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: checks request and read data against the model after the edge
    task automatic cyc(input string tag);
        @(posedge clk);
        #2;
        if (rst_req === 1'b1) pulses++;
        check({tag, " rst_req"}, {15'd0, rst_req}, {15'd0, m_req});
        check({tag, " rdata"}, bus_rdata, exp_rd(addr));
        #2;
    endtask

    task automatic idle(input int n, input string tag);
        bus_sel = 1'b0; bus_wr = 1'b0; addr = 4'h8;
        repeat (n) cyc(tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b1; addr = a; bus_wdata = d;
        cyc(tag);
        bus_sel = 1'b0; bus_wr = 1'b0; addr = 4'h8;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; addr = a;
        #1;
        check(tag, bus_rdata, exp);
        cyc(tag);
        bus_sel = 1'b0; addr = 4'h8;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int p0;
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) cyc("R1 reset");
        rst = 1'b0;

        // R1: reset values
        rd_chk(4'h0, 16'h0000, "R1 limit");
        rd_chk(4'h4, 16'h0000, "R1 enable");
        rd_chk(4'h8, 16'h0000, "R1 counter");
        rd_chk(4'hC, 16'h0000, "R1 control");
        check("R1 no request", {15'd0, rst_req}, 16'd0);

        // R2: map, ignored bits, readback
        wr_reg(4'h0, 16'hBEEF, "R2");
        rd_chk(4'h0, 16'hBEEF, "R2 limit readback");
        wr_reg(4'hC, 16'hFFFF, "R2");
        rd_chk(4'hC, 16'h003F, "R2 control width");
        wr_reg(4'h4, 16'hFFFE, "R2");
        rd_chk(4'h4, 16'h0000, "R2 enable bit0 only");
        wr_reg(4'h8, 16'h1234, "R2");
        rd_chk(4'h8, 16'h1234, "R2 counter readback");
        wr_reg(4'hC, 16'h0000, "R2");
        wr_reg(4'h8, 16'h0000, "R2");

        // R3/R7: count to match at divide by 1
        src_stb = 3'b001;
        wr_reg(4'h0, 16'd5, "R7");
        wr_reg(4'hC, 16'h0001, "R7");
        wr_reg(4'h4, 16'h0001, "R7");
        pulses = 0;
        idle(10, "R7");
        check("R7 one pulse", 16'(pulses), 16'd1);
        rd_chk(4'h8, 16'd5, "R7 holds at limit");
        idle(20, "R7");
        check("R7 no repeat pulse", 16'(pulses), 16'd1);

        // R6: ping restarts
        wr_reg(4'h8, 16'd0, "R6");
        idle(3, "R6");
        rd_chk(4'h8, 16'd3, "R6 restart count");
        idle(10, "R6");
        check("R6 second timeout", 16'(pulses), 16'd2);

        // R5: stopped counting
        wr_reg(4'h4, 16'h0000, "R5");
        wr_reg(4'h8, 16'd1, "R5");
        idle(40, "R5");
        rd_chk(4'h8, 16'd1, "R5 hold when disabled");
        wr_reg(4'hC, 16'h0000, "R5");
        wr_reg(4'h4, 16'h0001, "R5");
        idle(40, "R5");
        rd_chk(4'h8, 16'd1, "R5 hold with no source");
        check("R5 no pulse", 16'(pulses), 16'd2);

        // R3: only the selected source counts
        wr_reg(4'h0, 16'hFFFF, "R3");
        wr_reg(4'hC, 16'h0002, "R3");
        src_stb = 3'b101;
        idle(30, "R3");
        rd_chk(4'h8, 16'd1, "R3 unselected sources ignored");
        src_stb = 3'b010;
        idle(7, "R3");
        src_stb = 3'b000;
        rd_chk(4'h8, 16'd8, "R3 selected source counts");

        // R4: prescale codes
        src_stb = 3'b001;
        wr_reg(4'hC, 16'h0011, "R4");
        wr_reg(4'h8, 16'd0, "R4");
        idle(32, "R4");
        rd_chk(4'h8, 16'd2, "R4 divide by 16");
        wr_reg(4'hC, 16'h0031, "R4");
        wr_reg(4'h8, 16'd0, "R4");
        idle(1023, "R4");
        rd_chk(4'h8, 16'd0, "R4 code 6 before 1024");
        rd_chk(4'h8, 16'd1, "R4 code 6 divides by 1024");

        // R9: wrap past 0xFFFF
        wr_reg(4'h4, 16'h0000, "R9");
        wr_reg(4'hC, 16'h0001, "R9");
        wr_reg(4'h0, 16'd2, "R9");
        wr_reg(4'h8, 16'hFFFE, "R9");
        wr_reg(4'h4, 16'h0001, "R9");
        p0 = pulses;
        rd_chk(4'h8, 16'hFFFE, "R9 start");
        rd_chk(4'h8, 16'hFFFF, "R9 top");
        rd_chk(4'h8, 16'h0000, "R9 wrapped");
        idle(3, "R9");
        check("R9 timeout after wrap", 16'(pulses - p0), 16'd1);

        // R8: reconfiguration order with strobes running
        p0 = pulses;
        wr_reg(4'h4, 16'h0000, "R8");
        wr_reg(4'hC, 16'h0000, "R8");
        wr_reg(4'h0, 16'd4, "R8");
        wr_reg(4'h8, 16'd0, "R8");
        wr_reg(4'hC, 16'h0001, "R8");
        wr_reg(4'h4, 16'h0001, "R8");
        idle(3, "R8");
        check("R8 no spurious request", 16'(pulses - p0), 16'd0);
        idle(6, "R8");
        check("R8 real timeout", 16'(pulses - p0), 16'd1);

        // Random mix, checked every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            src_stb = 3'($urandom);
            r = int'($urandom % 100);
            if (r < 6) begin
                int k;
                logic [15:0] d;
                k = int'($urandom % 4);
                case (k)
                    0: d = 16'($urandom % 48);
                    1: d = ($urandom % 5 == 0) ? 16'h0000 : 16'h0001;
                    2: d = ($urandom % 2 == 0) ? 16'h0000 : 16'($urandom % 48);
                    default: d = {10'd0, 3'($urandom % 3), 3'($urandom)};
                endcase
                bus_sel = 1'b1; bus_wr = 1'b1; addr = {2'(k), 2'($urandom)}; bus_wdata = d;
                cyc("random R6 write");
            end else begin
                bus_sel = 1'b0; bus_wr = 1'b0; addr = {2'($urandom), 2'($urandom)};
                cyc("random R7 run");
            end
        end
        idle(2, "end");
        report();
    end

endmodule